// File: doc/BRIEF.md
# Permutation Address Table Builder

This block prepares the address permutation used by a turbo-style encoder or decoder. Whenever a new frame length is applied with a start pulse, the block picks the two coefficients of the quadratic polynomial for that length from a small built-in table. It then steps through every index of the frame and stores the permuted address of each index in an on-chip two-port memory. When the whole table is in place it raises a ready flag and holds it.

After that, the consumer reads the memory without any further computation. It places a sequential index on the read port and receives the permuted address on the following cycle. The polynomial is evaluated with additions only. The running address and its first difference are each kept reduced modulo the frame length, so every step costs two additions, each followed by at most one subtraction.

Top module: `qpp_intlv_gen`

## Requirements
- R1: After synchronous reset, `tbl_ready`, `gen_busy` and `cfg_bad` are all low.
- R2: A `cfg_start` pulse sampled while `gen_busy` is low captures `cfg_k` and clears `tbl_ready` and `cfg_bad`. From the next cycle, `gen_busy` reads high.
- R3: The supported frame lengths and their (f1, f2) pairs are: 40 (3, 10), 48 (7, 12), 56 (19, 42), 64 (7, 16), 128 (15, 32), 256 (15, 32) and 512 (31, 64). For each of these, table entry i holds (f1·i + f2·i²) mod K for every i from 0 to K−1.
- R4: The table is filled at one entry per cycle, in increasing index order starting at 0, with the write location equal to the index. The first value written is 0.
- R5: For a supported K, `tbl_ready` rises, and `gen_busy` falls, on the (K+1)-th rising clock edge after the edge that accepted the start.
- R6: A K outside the supported set, or a K above `MAX_K`, sets `cfg_bad` on the edge after acceptance and returns the block to idle. `tbl_ready` stays low and the stored table is not written.
- R7: A `cfg_start` pulse that arrives while `gen_busy` is high is ignored. The frame length in use, the fill timing and the table contents are unchanged.
- R8: `rd_addr` returns the table entry at `rd_idx` one clock after `rd_idx` is sampled.
- R9: Once high, `tbl_ready` stays high until the next accepted start. `tbl_ready`, `gen_busy` and `cfg_bad` are never high together in any pair.
- R10: Every value written into the table is below the captured K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Request to rebuild the table for `cfg_k` |
| cfg_k | input | 13 | Frame length to build for |
| gen_busy | output | 1 | Table is being looked up or filled |
| tbl_ready | output | 1 | Table for the captured K is complete |
| cfg_bad | output | 1 | Last accepted K was not supported |
| rd_idx | input | AW | Sequential index on the read port |
| rd_addr | output | AW | Permuted address for `rd_idx`, one cycle later |

## Verification
The assertions rely on the inputs being synchronous to `clk`. They also rely on `cfg_k` being read only in the cycle in which a start is accepted, so the properties check the captured length and not the live pin. The stimulus changes `cfg_start`, `cfg_k` and `rd_idx` only on falling edges. It holds every start to a single cycle, and it issues reads only after `tbl_ready` is seen, so the read-port check never meets a half-built table. The one start sent during a fill is placed mid-frame on purpose, to exercise the rule that such a start is dropped.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

    // Width of a frame length value (covers the largest standard length)
    localparam int KW = 13;

    typedef logic [KW-1:0] kval_t;

    typedef struct packed {
        kval_t len;
        kval_t c1;
        kval_t c2;
    } coef_row_t;

    localparam int N_ROWS = 7;

    localparam coef_row_t COEF_TAB [N_ROWS] = '{
        '{len: 13'd40,  c1: 13'd3,  c2: 13'd10},
        '{len: 13'd48,  c1: 13'd7,  c2: 13'd12},
        '{len: 13'd56,  c1: 13'd19, c2: 13'd42},
        '{len: 13'd64,  c1: 13'd7,  c2: 13'd16},
        '{len: 13'd128, c1: 13'd15, c2: 13'd32},
        '{len: 13'd256, c1: 13'd15, c2: 13'd32},
        '{len: 13'd512, c1: 13'd31, c2: 13'd64}
    };

    typedef enum logic [1:0] {
        GS_IDLE   = 2'd0,
        GS_LOOKUP = 2'd1,
        GS_FILL   = 2'd2
    } gen_state_t;

    // (a + b) mod m for a, b already below m: one add, one conditional subtract
    function automatic kval_t mod_add(input kval_t a, input kval_t b, input kval_t m);
        logic [KW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m})
            s = s - {1'b0, m};
        return s[KW-1:0];
    endfunction

endpackage

// File: rtl/qpp_coef_lut.sv
module qpp_coef_lut
    import qpp_pkg::*;
(
    input  kval_t k_in,
    output logic  hit,
    output kval_t f1,
    output kval_t f2
);

    logic [N_ROWS-1:0] row_hit;

    genvar r;
    generate
        for (r = 0; r < N_ROWS; r++) begin : g_row
            assign row_hit[r] = (k_in == COEF_TAB[r].len);
        end
    endgenerate

    always_comb begin
        hit = |row_hit;
        f1  = '0;
        f2  = '0;
        for (int j = 0; j < N_ROWS; j++) begin
            if (row_hit[j]) begin
                f1 = f1 | COEF_TAB[j].c1;
                f2 = f2 | COEF_TAB[j].c2;
            end
        end
    end

endmodule

// File: rtl/qpp_fill_engine.sv
module qpp_fill_engine
    import qpp_pkg::*;
#(
    parameter int MAX_K = 1024,
    parameter int AW    = 10
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  kval_t         k_in,
    output kval_t         k_lat,
    input  logic          coef_hit,
    input  kval_t         coef_f1,
    input  kval_t         coef_f2,
    output logic          busy,
    output logic          ready,
    output logic          err,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] wr_data
);

    localparam kval_t K_CAP = kval_t'(MAX_K);

    gen_state_t state_q;
    kval_t      idx_q;     // current index
    kval_t      pi_q;      // permuted address of idx_q
    kval_t      g_q;       // pi(idx+1) - pi(idx), mod K
    kval_t      d_q;       // second difference 2*f2, mod K
    logic       ready_q;
    logic       err_q;
    logic       last_idx;

    assign last_idx = (idx_q == (k_lat - kval_t'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_IDLE;
            k_lat   <= '0;
            idx_q   <= '0;
            pi_q    <= '0;
            g_q     <= '0;
            d_q     <= '0;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                GS_IDLE: begin
                    if (start) begin
                        k_lat   <= k_in;
                        ready_q <= 1'b0;
                        err_q   <= 1'b0;
                        state_q <= GS_LOOKUP;
                    end
                end
                GS_LOOKUP: begin
                    if (!coef_hit || (k_lat > K_CAP)) begin
                        err_q   <= 1'b1;
                        state_q <= GS_IDLE;
                    end else begin
                        idx_q   <= '0;
                        pi_q    <= '0;
                        g_q     <= mod_add(coef_f1, coef_f2, k_lat);
                        d_q     <= mod_add(coef_f2, coef_f2, k_lat);
                        state_q <= GS_FILL;
                    end
                end
                GS_FILL: begin
                    pi_q  <= mod_add(pi_q, g_q, k_lat);
                    g_q   <= mod_add(g_q, d_q, k_lat);
                    idx_q <= idx_q + kval_t'(1);
                    if (last_idx) begin
                        ready_q <= 1'b1;
                        state_q <= GS_IDLE;
                    end
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != GS_IDLE);
    assign ready   = ready_q;
    assign err     = err_q;
    assign wr_en   = (state_q == GS_FILL);
    assign wr_addr = idx_q[AW-1:0];
    assign wr_data = pi_q[AW-1:0];

endmodule

// File: rtl/qpp_addr_ram.sv
module qpp_addr_ram #(
    parameter int AW = 10,
    parameter int DW = 10
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/qpp_intlv_gen.sv
module qpp_intlv_gen
    import qpp_pkg::*;
#(
    parameter int MAX_K = 1024,
    localparam int AW   = $clog2(MAX_K)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_start,
    input  logic [12:0]   cfg_k,
    output logic          gen_busy,
    output logic          tbl_ready,
    output logic          cfg_bad,
    input  logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_addr
);

    kval_t         k_lat;
    logic          coef_hit;
    kval_t         coef_f1;
    kval_t         coef_f2;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] wr_data;

    qpp_coef_lut u_lut (
        .k_in (k_lat),
        .hit  (coef_hit),
        .f1   (coef_f1),
        .f2   (coef_f2)
    );

    qpp_fill_engine #(.MAX_K(MAX_K), .AW(AW)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (cfg_start),
        .k_in     (cfg_k),
        .k_lat    (k_lat),
        .coef_hit (coef_hit),
        .coef_f1  (coef_f1),
        .coef_f2  (coef_f2),
        .busy     (gen_busy),
        .ready    (tbl_ready),
        .err      (cfg_bad),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    qpp_addr_ram #(.AW(AW), .DW(AW)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_idx),
        .rdata (rd_addr)
    );

endmodule

// File: rtl/qpp_intlv_chk.sv
module qpp_intlv_chk
    import qpp_pkg::*;
#(
    parameter int AW = 10
)(
    input logic          clk,
    input logic          rst,
    input logic          cfg_start,
    input logic          gen_busy,
    input logic          tbl_ready,
    input logic          cfg_bad,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] wr_data,
    input kval_t         k_lat
);

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_start && !gen_busy) |=> (gen_busy && !tbl_ready && !cfg_bad));

    // R4
    fill_first_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !$past(wr_en)) |-> (wr_addr == '0 && wr_data == '0));

    // R4
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    // R10
    value_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ({{(KW-AW){1'b0}}, wr_data} < k_lat));

    // R5
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(gen_busy) |-> (tbl_ready != cfg_bad));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({gen_busy, tbl_ready, cfg_bad}) <= 1);

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_ready && !cfg_start) |=> tbl_ready);

    // R6
    bad_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |-> !wr_en);

endmodule

bind qpp_intlv_gen qpp_intlv_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_start (cfg_start),
    .gen_busy  (gen_busy),
    .tbl_ready (tbl_ready),
    .cfg_bad   (cfg_bad),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .k_lat     (k_lat)
);

// File: tb/qpp_intlv_gen_tb.sv
module qpp_intlv_gen_tb;

    localparam int MAX_K = 1024;
    localparam int AW    = $clog2(MAX_K);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_start = 1'b0;
    logic [12:0]   cfg_k = '0;
    logic          gen_busy;
    logic          tbl_ready;
    logic          cfg_bad;
    logic [AW-1:0] rd_idx = '0;
    logic [AW-1:0] rd_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    qpp_intlv_gen #(.MAX_K(MAX_K)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_start (cfg_start),
        .cfg_k     (cfg_k),
        .gen_busy  (gen_busy),
        .tbl_ready (tbl_ready),
        .cfg_bad   (cfg_bad),
        .rd_idx    (rd_idx),
        .rd_addr   (rd_addr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint perm(input int k, input int i);
        longint a, b;
        case (k)
            40:  begin a = 3;  b = 10; end
            48:  begin a = 7;  b = 12; end
            56:  begin a = 19; b = 42; end
            64:  begin a = 7;  b = 16; end
            128: begin a = 15; b = 32; end
            256: begin a = 15; b = 32; end
            default: begin a = 31; b = 64; end
        endcase
        return (a * i + b * i * i) % k;
    endfunction

    // Accept a start, wait for the end of the fill, return edges counted
    task automatic run_start(input int k, input bit poke, output int n);
        @(negedge clk);
        cfg_k     = 13'(k);
        cfg_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_start = 1'b0;
        check(gen_busy == 1'b1, "R2 busy", gen_busy, 1);
        check(tbl_ready == 1'b0, "R2 ready cleared", tbl_ready, 0);
        check(cfg_bad == 1'b0, "R2 error cleared", cfg_bad, 0);
        n = 0;
        while (gen_busy && n < 5000) begin
            cfg_start = poke && (n == 10);
            if (poke && n == 10) cfg_k = 13'd128;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        cfg_start = 1'b0;
    endtask

    task automatic read_table(input int k, input string req);
        for (int i = 0; i < k; i++) begin
            rd_idx = AW'(i);
            @(posedge clk);
            @(negedge clk);
            check(longint'(rd_addr) == perm(k, i), req, rd_addr, perm(k, i));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R1
        check(tbl_ready == 1'b0, "R1 ready", tbl_ready, 0);
        check(gen_busy == 1'b0, "R1 busy", gen_busy, 0);
        check(cfg_bad == 1'b0, "R1 error", cfg_bad, 0);
    endtask

    task automatic t_build(input int k);
        int n;
        run_start(k, 1'b0, n);
        // R5
        check(n == k + 1, "R5 fill latency", n, k + 1);
        check(tbl_ready == 1'b1, "R5 ready", tbl_ready, 1);
        check(gen_busy == 1'b0, "R5 busy low", gen_busy, 0);
        // R3 R4 R8
        read_table(k, "R3 R4 R8 table entry");
        // R9
        check(tbl_ready == 1'b1, "R9 ready held", tbl_ready, 1);
    endtask

    task automatic t_busy_start();
        int n;
        run_start(40, 1'b1, n);
        // R7
        check(n == 41, "R7 timing kept", n, 41);
        check(tbl_ready == 1'b1, "R7 ready", tbl_ready, 1);
        read_table(40, "R7 table kept");
        @(negedge clk);
        check(gen_busy == 1'b0, "R7 no second fill", gen_busy, 0);
    endtask

    task automatic t_bad(input int k);
        @(negedge clk);
        cfg_k     = 13'(k);
        cfg_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_start = 1'b0;
        // R9 new start clears ready
        check(tbl_ready == 1'b0, "R9 ready cleared", tbl_ready, 0);
        @(posedge clk);
        @(negedge clk);
        // R6
        check(cfg_bad == 1'b1, "R6 error set", cfg_bad, 1);
        check(gen_busy == 1'b0, "R6 idle", gen_busy, 0);
        check(tbl_ready == 1'b0, "R6 ready low", tbl_ready, 0);
        // R6: earlier table (K=64) must be untouched
        read_table(64, "R6 table untouched");
        check(tbl_ready == 1'b0, "R6 ready still low", tbl_ready, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                check(1'b0, "watchdog", cyc, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_build(40);
        t_build(48);
        t_build(56);
        t_build(128);
        t_build(256);
        t_build(512);
        t_busy_start();
        t_build(64);
        t_bad(100);
        t_bad(2048);
        t_build(40);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule